// File: doc/BRIEF.md
# Outbound Request Descriptor Bank

This block holds four independent descriptor slots through which a host queues outbound serial-interconnect request transactions. The host reaches every slot over one shared configuration bus. Each slot has six word registers: an extended address, an address, a data pointer, a byte count, a type register whose low byte is the packet type, and a command word. Writing the command word arms the slot. From the next cycle the slot reports busy and locks itself against further host writes.

An armed slot whose packet format is supported asks a downstream transaction engine to take it, using a valid/ready handshake. When several slots are armed, they are granted in round-robin order. The engine later returns a completion strobe with the slot index and a 3-bit result code. The slot latches that code and, if the command asked for it, raises a per-slot interrupt that the host must acknowledge. A slot whose format type is not supported never reaches the engine. It finishes by itself with the programming-error code. The completion code becomes visible only once the slot is idle again.

Because the slots are independent, up to four requests that need a response can be outstanding at once.

Top module: `req_desc_bank`

## Requirements
- R1: After reset every slot is idle, every status word reads zero (busy 0, code 000), no interrupt is raised and `eng_valid` is low.
- R2: The bus address is `{slot[1:0], offset[2:0]}`. For an idle slot, offsets 0 to 5 read back the last value written. Offset 6 is the status word, with busy in bit 31 and the completion code in bits 2:0. Offset 7 reads zero. Writes to offsets 6 and 7 change nothing.
- R3: A write to offset 5 (the command word) of an idle slot arms it, and its busy bit reads 1 from the cycle after the write.
- R4: While a slot is busy, host writes to any of its offsets are ignored. A read at any of its offsets returns 0x8000_0000 (busy set, code zero).
- R5: An armed slot whose format type (offset 4, bits 7:4) is 2, 5, 6, 8, 10, 11 or 13 asserts `eng_valid`. It presents its index on `eng_set`, offset 4 bits 7:0 on `eng_ptype` and its command word on `eng_cmd`. It is taken on a cycle where `eng_valid` and `eng_ready` are both high.
- R6: An armed slot with any other format type never asserts `eng_valid`. It is busy for exactly one cycle and then idles with code 100.
- R7: A `cpl_valid` strobe whose `cpl_set` names a slot that has been taken latches `cpl_code` into that slot. If command bit 31 is 0, the slot goes idle on the next cycle. A strobe naming a slot that has not been taken has no effect.
- R8: If command bit 31 is 1, completion raises `irq[slot]` and the slot stays busy. Busy and the interrupt both clear on the cycle after `irq_ack[slot]`.
- R9: When several slots request at once, grants rotate. The search starts at the slot after the one most recently taken, and starts at slot 0 after reset.
- R10: All four slots can be armed and taken at the same time, and each keeps its own completion code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read enable (read data is combinational) |
| cfg_addr | input | 5 | Slot index and register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, zero when `cfg_rd` is low |
| eng_valid | output | 1 | A slot requests the transaction engine |
| eng_ready | input | 1 | Engine accepts the presented slot |
| eng_set | output | 2 | Index of the presented slot |
| eng_ptype | output | 8 | Packet type of the presented slot |
| eng_cmd | output | 32 | Command word of the presented slot |
| cpl_valid | input | 1 | Completion strobe |
| cpl_set | input | 2 | Slot index of the completion |
| cpl_code | input | 3 | Completion result code |
| irq_ack | input | 4 | Per-slot interrupt acknowledge |
| irq | output | 4 | Per-slot interrupt request |

## Verification
The assertions check four things on every cycle. A command write to an idle slot always raises busy on the next cycle. The engine is only ever offered a busy slot with a supported format type, and that slot remains busy once taken. An interrupt implies busy, and an acknowledge clears both. A read from a busy slot returns only the busy pattern. Other behaviour can only be shown by the bench's scenarios, compared each cycle against a behavioural model. This covers the order of round-robin grants, the latched completion codes and their hiding while busy, the one-cycle life of an invalid-type request, and the discarding of writes to locked slots or to the status offset.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
    localparam int WORD_W     = 32;
    localparam int NREGS      = 6;
    localparam int REG_W      = 3;
    localparam int TYPE_OFF   = 4;
    localparam int CMD_OFF    = 5;
    localparam int STATUS_OFF = 6;
    localparam int INTREQ_BIT = 31;
    localparam int CODE_W     = 3;
    localparam logic [CODE_W-1:0] CODE_BADPROG = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_IRQ    = 2'd3
    } slot_st_e;

    typedef logic [NREGS-1:0][WORD_W-1:0] regfile_t;

    // Supported format types (upper nibble of the packet type)
    function automatic logic ftype_ok(input logic [3:0] ft);
        case (ft)
            4'd2, 4'd5, 4'd6, 4'd8, 4'd10, 4'd11, 4'd13: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rdb_rr_arb.sv
module rdb_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        ptr_d = ptr_q;
        for (int k = 0; k < N; k++) begin
            if (!any && req[(int'(ptr_q) + k) % N]) begin
                any = 1'b1;
                idx = IDX_W'((int'(ptr_q) + k) % N);
            end
        end
        if (any && take) begin
            ptr_d = (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/rdb_slot.sv
module rdb_slot
    import rdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              launch,
    input  logic              cpl_hit,
    input  logic [CODE_W-1:0] cpl_code,
    input  logic              irq_ack,
    output logic              busy,
    output logic              req,
    output logic              irq,
    output logic [CODE_W-1:0] code,
    output regfile_t          regs
);
    typedef struct packed {
        slot_st_e          st;
        regfile_t          regs;
        logic [CODE_W-1:0] code;
    } slot_state_t;

    slot_state_t s_d, s_q;
    logic int_req;
    logic type_ok;

    always_comb begin
        s_d     = s_q;
        int_req = s_q.regs[CMD_OFF][INTREQ_BIT];
        type_ok = ftype_ok(s_q.regs[TYPE_OFF][7:4]);
        case (s_q.st)
            ST_IDLE: begin
                if (wr_en && int'(wr_off) < NREGS) begin
                    s_d.regs[wr_off] = wr_data;
                    if (int'(wr_off) == CMD_OFF) s_d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!type_ok) begin
                    s_d.code = CODE_BADPROG;
                    s_d.st   = int_req ? ST_IRQ : ST_IDLE;
                end else if (launch) begin
                    s_d.st = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (cpl_hit) begin
                    s_d.code = cpl_code;
                    s_d.st   = int_req ? ST_IRQ : ST_IDLE;
                end
            end
            default: begin
                if (irq_ack) s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != ST_IDLE);
    assign req  = (s_q.st == ST_ARMED) && type_ok;
    assign irq  = (s_q.st == ST_IRQ);
    assign code = s_q.code;
    assign regs = s_q.regs;
endmodule

// File: rtl/req_desc_bank.sv
module req_desc_bank
    import rdb_pkg::*;
#(
    parameter  int NSETS  = 4,
    localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int ADDR_W = SET_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [SET_W-1:0]  eng_set,
    output logic [7:0]        eng_ptype,
    output logic [WORD_W-1:0] eng_cmd,
    input  logic              cpl_valid,
    input  logic [SET_W-1:0]  cpl_set,
    input  logic [CODE_W-1:0] cpl_code,
    input  logic [NSETS-1:0]  irq_ack,
    output logic [NSETS-1:0]  irq
);
    localparam logic [WORD_W-1:0] BUSY_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    logic [SET_W-1:0]  sel_set;
    logic [REG_W-1:0]  sel_off;
    logic [NSETS-1:0]  set_busy;
    logic [NSETS-1:0]  set_req;
    logic [CODE_W-1:0] set_code [NSETS];
    regfile_t          set_regs [NSETS];
    logic              gnt_any;
    logic [SET_W-1:0]  gnt_idx;

    assign sel_set = cfg_addr[ADDR_W-1:REG_W];
    assign sel_off = cfg_addr[REG_W-1:0];

    for (genvar g = 0; g < NSETS; g++) begin : g_slot
        rdb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_wr && sel_set == SET_W'(g)),
            .wr_off   (sel_off),
            .wr_data  (cfg_wdata),
            .launch   (gnt_any && eng_ready && gnt_idx == SET_W'(g)),
            .cpl_hit  (cpl_valid && cpl_set == SET_W'(g)),
            .cpl_code (cpl_code),
            .irq_ack  (irq_ack[g]),
            .busy     (set_busy[g]),
            .req      (set_req[g]),
            .irq      (irq[g]),
            .code     (set_code[g]),
            .regs     (set_regs[g])
        );
    end

    rdb_rr_arb #(.N(NSETS), .IDX_W(SET_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (set_req),
        .take  (eng_ready),
        .any   (gnt_any),
        .idx   (gnt_idx)
    );

    assign eng_valid = gnt_any;
    assign eng_set   = gnt_idx;
    assign eng_ptype = set_regs[gnt_idx][TYPE_OFF][7:0];
    assign eng_cmd   = set_regs[gnt_idx][CMD_OFF];

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd && int'(sel_set) < NSETS) begin
            if (set_busy[sel_set]) begin
                cfg_rdata = BUSY_WORD;
            end else if (int'(sel_off) < NREGS) begin
                cfg_rdata = set_regs[sel_set][sel_off];
            end else if (int'(sel_off) == STATUS_OFF) begin
                cfg_rdata = {{(WORD_W-CODE_W){1'b0}}, set_code[sel_set]};
            end
        end
    end
endmodule

// File: rtl/req_desc_bank_chk.sv
module req_desc_bank_chk
    import rdb_pkg::*;
#(
    parameter  int NSETS  = 4,
    localparam int SET_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int ADDR_W = SET_W + REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              eng_valid,
    input logic              eng_ready,
    input logic [SET_W-1:0]  eng_set,
    input logic [7:0]        eng_ptype,
    input logic [NSETS-1:0]  irq,
    input logic [NSETS-1:0]  irq_ack,
    input logic [NSETS-1:0]  set_busy
);
    for (genvar i = 0; i < NSETS; i++) begin : g_chk
        // R3
        arm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_addr[ADDR_W-1:REG_W] == SET_W'(i)
                    && cfg_addr[REG_W-1:0] == REG_W'(CMD_OFF) && !set_busy[i])
            |=> set_busy[i]);
        // R8
        irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> set_busy[i]);
        // R8
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && irq_ack[i]) |=> (!set_busy[i] && !irq[i]));
    end

    // R5
    offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> set_busy[eng_set]);
    // R6
    offer_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> ftype_ok(eng_ptype[7:4]));
    // R5
    taken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_ready) |=> set_busy[$past(eng_set)]);
    // R4
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && set_busy[cfg_addr[ADDR_W-1:REG_W]])
        |-> cfg_rdata == {1'b1, {(WORD_W-1){1'b0}}});
endmodule

bind req_desc_bank req_desc_bank_chk #(.NSETS(NSETS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .eng_valid (eng_valid),
    .eng_ready (eng_ready),
    .eng_set   (eng_set),
    .eng_ptype (eng_ptype),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .set_busy  (set_busy)
);

// File: tb/req_desc_bank_tb_top.sv
module req_desc_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        eng_valid, eng_ready = 1'b0;
    logic [1:0]  eng_set;
    logic [7:0]  eng_ptype;
    logic [31:0] eng_cmd;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_set = '0;
    logic [2:0]  cpl_code = '0;
    logic [3:0]  irq_ack = '0;
    logic [3:0]  irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    req_desc_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_set(eng_set),
        .eng_ptype(eng_ptype), .eng_cmd(eng_cmd), .cpl_valid(cpl_valid),
        .cpl_set(cpl_set), .cpl_code(cpl_code), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st [4];        // 0 idle, 1 armed, 2 taken, 3 waiting ack
    logic [31:0] m_reg [4][6];
    logic [2:0]  m_code [4];
    int          m_ptr;

    function automatic bit m_ok(int s);
        return int'(m_reg[s][4][7:4]) inside {2, 5, 6, 8, 10, 11, 13};
    endfunction

    function automatic int m_grant();
        for (int k = 0; k < 4; k++) begin
            if (m_st[(m_ptr + k) % 4] == 1 && m_ok((m_ptr + k) % 4))
                return (m_ptr + k) % 4;
        end
        return -1;
    endfunction

    function automatic logic [31:0] m_read(int s, int o);
        if (m_st[s] != 0) return 32'h8000_0000;
        if (o < 6)        return m_reg[s][o];
        if (o == 6)       return {29'b0, m_code[s]};
        return 32'h0;
    endfunction

    task automatic m_reset();
        m_ptr = 0;
        for (int s = 0; s < 4; s++) begin
            m_st[s] = 0;
            m_code[s] = 3'b000;
            for (int o = 0; o < 6; o++) m_reg[s][o] = 32'h0;
        end
    endtask

    initial m_reset();

    always @(posedge clk) begin
        int g;
        if (!rst_n) begin
            m_reset();
        end else begin
            g = m_grant();
            for (int s = 0; s < 4; s++) begin
                case (m_st[s])
                    0: if (cfg_wr && int'(cfg_addr[4:3]) == s && int'(cfg_addr[2:0]) < 6) begin
                           m_reg[s][cfg_addr[2:0]] = cfg_wdata;
                           if (cfg_addr[2:0] == 3'd5) m_st[s] = 1;
                       end
                    1: if (!m_ok(s)) begin
                           m_code[s] = 3'b100;
                           m_st[s] = m_reg[s][5][31] ? 3 : 0;
                       end else if (g == s && eng_ready) m_st[s] = 2;
                    2: if (cpl_valid && int'(cpl_set) == s) begin
                           m_code[s] = cpl_code;
                           m_st[s] = m_reg[s][5][31] ? 3 : 0;
                       end
                    default: if (irq_ack[s]) m_st[s] = 0;
                endcase
            end
            if (g >= 0 && eng_ready) m_ptr = (g + 1) % 4;
        end
    end

    // per-cycle comparison, mid-cycle
    always @(negedge clk) begin
        int g;
        logic [3:0] exp_irq;
        if (rst_n && !done) begin
            g = m_grant();
            chk("R5 R6 eng_valid", {31'b0, eng_valid}, {31'b0, g >= 0});
            if (g >= 0) begin
                chk("R9 eng_set", {30'b0, eng_set}, 32'(g));
                chk("R5 eng_ptype", {24'b0, eng_ptype}, {24'b0, m_reg[g][4][7:0]});
                chk("R5 eng_cmd", eng_cmd, m_reg[g][5]);
            end
            for (int s = 0; s < 4; s++) exp_irq[s] = (m_st[s] == 3);
            chk("R8 irq", {28'b0, irq}, {28'b0, exp_irq});
            chk("R2 R4 cfg_rdata", cfg_rdata,
                cfg_rd ? m_read(int'(cfg_addr[4:3]), int'(cfg_addr[2:0])) : 32'h0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int s, int o, logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = 5'(s * 8 + o); cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic peek(int s, int o, logic [31:0] exp, string tag);
        cfg_addr = 5'(s * 8 + o);
        @(negedge clk);
        chk(tag, cfg_rdata, exp);
        step();
    endtask

    task automatic load(int s, logic [7:0] ptype);
        wr(s, 0, 32'h1000_0000 + s);
        wr(s, 1, 32'h2000_0000 + s * 16);
        wr(s, 2, 32'h3000_0000 + s * 16);
        wr(s, 3, 32'h0000_0040 + s);
        wr(s, 4, {24'h0, ptype});
    endtask

    task automatic cpl(int s, logic [2:0] c);
        cpl_valid = 1'b1; cpl_set = 2'(s); cpl_code = c;
        step();
        cpl_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        cfg_rd = 1'b1;
        // R1 reset state
        for (int s = 0; s < 4; s++) peek(s, 6, 32'h0, "R1 status after reset");
        chk("R1 no irq", {28'b0, irq}, 32'h0);

        // R3, R4, R7: slot 0 posted-style request
        load(0, 8'h25);
        wr(0, 5, 32'h0000_00AB);
        peek(0, 6, 32'h8000_0000, "R3 busy after command");
        wr(0, 1, 32'hDEAD_BEEF);                       // ignored while busy
        peek(0, 1, 32'h8000_0000, "R4 busy slot read");
        eng_ready = 1'b1; step(); eng_ready = 1'b0;
        cpl(2, 3'b110);                                // slot 2 not taken: ignored
        cpl(0, 3'b011);
        peek(0, 6, 32'h0000_0003, "R7 latched code");
        peek(0, 1, 32'h2000_0000, "R4 write while busy dropped");
        peek(2, 6, 32'h0, "R7 stray completion ignored");

        // R6 invalid format type
        load(1, 8'h30);
        wr(1, 5, 32'h0000_0000);
        peek(1, 6, 32'h8000_0000, "R6 busy one cycle");
        peek(1, 6, 32'h0000_0004, "R6 code 100");

        // R8 interrupt path
        load(2, 8'h80);
        wr(2, 5, 32'h8000_0012);
        eng_ready = 1'b1; step(); eng_ready = 1'b0;
        cpl(2, 3'b000);
        @(negedge clk);
        chk("R8 irq raised", {28'b0, irq}, 32'h4);
        peek(2, 6, 32'h8000_0000, "R8 busy until ack");
        irq_ack = 4'b0100; step(); irq_ack = 4'b0000;
        peek(2, 6, 32'h0, "R8 cleared after ack");

        // R9, R10 four outstanding, round-robin from slot 3
        wr(1, 4, 32'h0000_0050);
        load(3, 8'hD0);
        for (int s = 0; s < 4; s++) wr(s, 5, 32'h0000_0100 * (s + 1));
        for (int s = 0; s < 4; s++) peek(s, 6, 32'h8000_0000, "R10 all busy");
        eng_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 grant order", {30'b0, eng_set}, 32'((k + 3) % 4));
            step();
        end
        eng_ready = 1'b0;
        cpl(0, 3'b001); cpl(1, 3'b010); cpl(2, 3'b101); cpl(3, 3'b111);
        peek(0, 6, 32'h1, "R10 code slot 0");
        peek(1, 6, 32'h2, "R10 code slot 1");
        peek(2, 6, 32'h5, "R10 code slot 2");
        peek(3, 6, 32'h7, "R10 code slot 3");

        // R2 status and unused offsets
        wr(3, 6, 32'hFFFF_FFFF);
        wr(3, 7, 32'hFFFF_FFFF);
        peek(3, 6, 32'h7, "R2 status write ignored");
        peek(3, 7, 32'h0, "R2 offset 7 reads zero");
        peek(3, 4, 32'h0000_00D0, "R2 readback");
        step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule